// File: doc/BRIEF.md
# Latched Status Event Register

This block keeps an 8-bit sticky record of status events for an instrument controller. A live condition vector is compared each clock with its value from the previous clock. Each bit of a programmable filter register arms that condition bit so that a 1-to-0 change latches the matching event bit. Two event positions have no live condition behind them. They are set directly by fault inputs: a failed calibration-memory read at motor startup, and loss of the head cable while the connection is being watched.

Software reads the event register through a small register port. A read of the whole register returns the value and clears every bit. A read of one bit returns that bit in the LSB and clears only that bit. A clear-all strobe empties the register. An enable register masks the events. The masked result is OR-reduced into one registered summary bit, which a higher-level status byte uses.

Top module: `status_event_reg`

## Requirements
- R1: When filter bit i is 1 and condition bit i goes from 1 on one clock to 0 on the next, event bit i is 1 after that second clock edge. This holds for every bit except 5 and 6. Rising edges, and falling edges of bits whose filter bit is 0, set nothing.
- R2: Once an event bit is 1, it stays 1 until a read or a clear removes it.
- R3: With rd_en_i=1 and rd_kind_i=0, rd_data_o shows the event register in the same cycle, and all event bits are cleared at the clock edge.
- R4: With rd_en_i=1 and rd_kind_i=1, rd_data_o[0] shows event bit rd_idx_i and the upper bits are 0. Only that event bit is cleared.
- R5: A clr_all_i pulse sets the whole event register to 0 at the next edge.
- R6: If a bit is set and cleared in the same cycle, whether by a read or by clr_all_i, the set wins and the bit is 1 afterwards.
- R7: A memfail_i pulse sets event bit 5 (weight 32).
- R8: Event bit 6 (weight 64) is set when cable_ok_i=0 while motor_on_i=1 or startup_i=1. While both are 0, cable_ok_i has no effect.
- R9: summary_o equals the OR of (event AND enable), one clock after those registers change. It is 0 after reset.
- R10: The filter register and the enable register reset to 0. They load wr_data_i when filt_wr_i or enab_wr_i is high. They read back with rd_kind_i=2 (filter) and rd_kind_i=3 (enable). rd_data_o is 0 when rd_en_i=0.
- R11: Condition bits 5 and 6 never set events, whatever the filter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | 8 | Live condition bits |
| wr_data_i | input | 8 | Write data for the filter and enable registers |
| filt_wr_i | input | 1 | Load the filter register |
| enab_wr_i | input | 1 | Load the enable register |
| rd_en_i | input | 1 | Read strobe |
| rd_kind_i | input | 2 | 0 event all, 1 event bit, 2 filter, 3 enable |
| rd_idx_i | input | 3 | Bit index for a single-bit read |
| rd_data_o | output | 8 | Read data, valid in the strobe cycle |
| clr_all_i | input | 1 | Clear the event register |
| motor_on_i | input | 1 | Motor running |
| startup_i | input | 1 | Motor startup in progress |
| memfail_i | input | 1 | Calibration memory read failed (pulse) |
| cable_ok_i | input | 1 | Head cable detected as connected |
| summary_o | output | 1 | Registered masked-OR summary |

## Verification
The hardest case to reach is a collision: a falling edge, or a fault pulse, lands in exactly the cycle when the same bit is cleared by a whole read, a single-bit read or clear-all. The bench builds this directly. It raises a condition bit, then drops it in the cycle that carries the read, and it checks both the returned value and the value read next. Random traffic then mixes reads, clears, filter rewrites and faults at rates high enough that such overlaps recur many times. The bench also checks that cable loss with the motor stopped does not set the cable event.

// File: rtl/sev_pkg.sv
package sev_pkg;

   typedef enum logic [1:0] {
      RD_EVT_ALL = 2'd0,
      RD_EVT_BIT = 2'd1,
      RD_FILTER  = 2'd2,
      RD_ENABLE  = 2'd3
   } sev_rd_kind_e;

   function automatic logic [31:0] bit_mask(input int unsigned pos);
      logic [31:0] m;
      m = 32'd0;
      m[pos] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/sev_edge_detect.sv
module sev_edge_detect #(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] SKIP_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_i,
   input  logic [WIDTH-1:0] filt_i,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] cond_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_d <= '0;
      else        cond_d <= cond_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (SKIP_MASK[b]) begin : g_skip
         assign fall_o[b] = 1'b0;
      end else begin : g_live
         assign fall_o[b] = filt_i[b] & cond_d[b] & ~cond_i[b];
      end
   end

endmodule

// File: rtl/sev_event_bits.sv
module sev_event_bits #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] evt_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_cell
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[b]) q <= 1'b1;
         else if (clr_i[b]) q <= 1'b0;
      end
      assign evt_o[b] = q;
   end

endmodule

// File: rtl/sev_summary.sv
module sev_summary #(
   parameter int unsigned WIDTH = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt_i,
   input  logic [WIDTH-1:0] enab_i,
   output logic             summary_o
);

   logic hit;
   assign hit = |(evt_i & enab_i);

   if (REGISTERED) begin : g_reg
      logic sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_q <= 1'b0;
         else        sum_q <= hit;
      end
      assign summary_o = sum_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign summary_o = hit;
   end

endmodule

// File: rtl/status_event_reg.sv
module status_event_reg
   import sev_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned MEMFAIL_POS = 5,
   parameter int unsigned CABLE_POS   = 6,
   parameter bit          SUM_REG     = 1'b1,
   localparam int unsigned IDXW       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             filt_wr_i,
   input  logic             enab_wr_i,
   input  logic             rd_en_i,
   input  logic [1:0]       rd_kind_i,
   input  logic [IDXW-1:0]  rd_idx_i,
   output logic [WIDTH-1:0] rd_data_o,
   input  logic             clr_all_i,
   input  logic             motor_on_i,
   input  logic             startup_i,
   input  logic             memfail_i,
   input  logic             cable_ok_i,
   output logic             summary_o
);

   localparam logic [31:0] MEM_M32  = bit_mask(MEMFAIL_POS);
   localparam logic [31:0] CAB_M32  = bit_mask(CABLE_POS);
   localparam logic [WIDTH-1:0] DISCRETE_MASK = MEM_M32[WIDTH-1:0] | CAB_M32[WIDTH-1:0];

   if (WIDTH < 2 || WIDTH > 32) begin : g_chk_width
      $error("status_event_reg: WIDTH must be in 2..32");
   end
   if (MEMFAIL_POS >= WIDTH || CABLE_POS >= WIDTH) begin : g_chk_pos
      $error("status_event_reg: discrete event position outside WIDTH");
   end
   if (MEMFAIL_POS == CABLE_POS) begin : g_chk_dup
      $error("status_event_reg: discrete event positions must differ");
   end

   logic [WIDTH-1:0] filt_q;
   logic [WIDTH-1:0] enab_q;
   logic [WIDTH-1:0] evt_q;
   logic [WIDTH-1:0] fall_vec;
   logic [WIDTH-1:0] disc_vec;
   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] clr_vec;
   logic [WIDTH-1:0] idx_onehot;
   sev_rd_kind_e     kind;

   assign kind = sev_rd_kind_e'(rd_kind_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= '0;
         enab_q <= '0;
      end else begin
         if (filt_wr_i) filt_q <= wr_data_i;
         if (enab_wr_i) enab_q <= wr_data_i;
      end
   end

   sev_edge_detect #(
      .WIDTH     (WIDTH),
      .SKIP_MASK (DISCRETE_MASK)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (cond_i),
      .filt_i (filt_q),
      .fall_o (fall_vec)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_disc
      if (b == MEMFAIL_POS) begin : g_mem
         assign disc_vec[b] = memfail_i;
      end else if (b == CABLE_POS) begin : g_cab
         assign disc_vec[b] = ~cable_ok_i & (motor_on_i | startup_i);
      end else begin : g_none
         assign disc_vec[b] = 1'b0;
      end
   end

   assign set_vec    = fall_vec | disc_vec;
   assign idx_onehot = {{(WIDTH-1){1'b0}}, 1'b1} << rd_idx_i;

   always_comb begin
      clr_vec = '0;
      if (clr_all_i) begin
         clr_vec = '1;
      end else if (rd_en_i) begin
         case (kind)
            RD_EVT_ALL: clr_vec = '1;
            RD_EVT_BIT: clr_vec = idx_onehot;
            default:    clr_vec = '0;
         endcase
      end
   end

   sev_event_bits #(
      .WIDTH (WIDTH)
   ) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .evt_o (evt_q)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_en_i) begin
         case (kind)
            RD_EVT_ALL: rd_data_o = evt_q;
            RD_EVT_BIT: rd_data_o = {{(WIDTH-1){1'b0}}, |(evt_q & idx_onehot)};
            RD_FILTER:  rd_data_o = filt_q;
            RD_ENABLE:  rd_data_o = enab_q;
            default:    rd_data_o = '0;
         endcase
      end
   end

   sev_summary #(
      .WIDTH      (WIDTH),
      .REGISTERED (SUM_REG)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_q),
      .enab_i    (enab_q),
      .summary_o (summary_o)
   );

endmodule

// File: rtl/sev_checker.sv
module sev_checker #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned MEMFAIL_POS = 5,
   parameter int unsigned CABLE_POS = 6,
   parameter bit          SUM_REG = 1'b1,
   parameter int unsigned IDXW = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cond_i,
   input logic             rd_en_i,
   input logic [1:0]       rd_kind_i,
   input logic [IDXW-1:0]  rd_idx_i,
   input logic             clr_all_i,
   input logic             motor_on_i,
   input logic             startup_i,
   input logic             memfail_i,
   input logic             cable_ok_i,
   input logic [WIDTH-1:0] evt_q,
   input logic [WIDTH-1:0] filt_q,
   input logic [WIDTH-1:0] enab_q,
   input logic             summary_o
);

   logic [WIDTH-1:0] cond_seen;
   logic [WIDTH-1:0] skip_m;
   logic [WIDTH-1:0] edge_chk;
   logic [WIDTH-1:0] disc_chk;
   logic [WIDTH-1:0] clr_chk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_seen <= '0;
      else        cond_seen <= cond_i;
   end

   always_comb begin
      skip_m = '0;
      skip_m[MEMFAIL_POS] = 1'b1;
      skip_m[CABLE_POS]   = 1'b1;
      disc_chk = '0;
      disc_chk[MEMFAIL_POS] = memfail_i;
      disc_chk[CABLE_POS]   = !cable_ok_i && (motor_on_i || startup_i);
      clr_chk = '0;
      if (clr_all_i || (rd_en_i && rd_kind_i == 2'd0)) clr_chk = '1;
      else if (rd_en_i && rd_kind_i == 2'd1) clr_chk[rd_idx_i] = 1'b1;
   end

   assign edge_chk = filt_q & cond_seen & ~cond_i & ~skip_m;

   assert_falling_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(edge_chk)) == $past(edge_chk)));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_q) & ~$past(clr_chk) & ~evt_q) == '0));

   assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> ((evt_q & ~$past(edge_chk | disc_chk)) == '0));

   assert_memfail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      memfail_i |=> evt_q[MEMFAIL_POS]);

   assert_cable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!motor_on_i && !startup_i && !evt_q[CABLE_POS]) |=> !evt_q[CABLE_POS]);

   if (SUM_REG) begin : g_sum_chk
      assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (summary_o == $past(|(evt_q & enab_q))));
   end

endmodule

bind status_event_reg sev_checker #(
   .WIDTH       (WIDTH),
   .MEMFAIL_POS (MEMFAIL_POS),
   .CABLE_POS   (CABLE_POS),
   .SUM_REG     (SUM_REG),
   .IDXW        (IDXW)
) u_sev_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cond_i     (cond_i),
   .rd_en_i    (rd_en_i),
   .rd_kind_i  (rd_kind_i),
   .rd_idx_i   (rd_idx_i),
   .clr_all_i  (clr_all_i),
   .motor_on_i (motor_on_i),
   .startup_i  (startup_i),
   .memfail_i  (memfail_i),
   .cable_ok_i (cable_ok_i),
   .evt_q      (evt_q),
   .filt_q     (filt_q),
   .enab_q     (enab_q),
   .summary_o  (summary_o)
);

// File: tb/test_status_event_reg.sv
module test_status_event_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cond = '0;
   logic [7:0] wdata = '0;
   logic       filt_wr = 0, enab_wr = 0, rd_en = 0, clr_all = 0;
   logic [1:0] rd_kind = '0;
   logic [2:0] rd_idx = '0;
   logic       motor_on = 0, startup = 0, memfail = 0, cable_ok = 1;
   logic [7:0] rd_data;
   logic       summary;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   logic [7:0] m_evt = '0, m_filt = '0, m_enab = '0, m_prev = '0;
   logic       m_sum = 0;

   always #5 clk = ~clk;

   status_event_reg i_status_event_reg (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .wr_data_i(wdata),
      .filt_wr_i(filt_wr), .enab_wr_i(enab_wr), .rd_en_i(rd_en),
      .rd_kind_i(rd_kind), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .clr_all_i(clr_all), .motor_on_i(motor_on), .startup_i(startup),
      .memfail_i(memfail), .cable_ok_i(cable_ok), .summary_o(summary)
   );

   function automatic logic [7:0] exp_read();
      if (!rd_en) return 8'h00;
      case (rd_kind)
         2'd0: return m_evt;
         2'd1: return {7'd0, m_evt[rd_idx]};
         2'd2: return m_filt;
         default: return m_enab;
      endcase
   endfunction

   function automatic logic [7:0] exp_next_evt();
      logic [7:0] s, c;
      s = m_filt & m_prev & ~cond & 8'b1001_1111;
      s[5] = memfail;
      s[6] = !cable_ok && (motor_on || startup);
      c = 8'h00;
      if (clr_all || (rd_en && rd_kind == 2'd0)) c = 8'hFF;
      else if (rd_en && rd_kind == 2'd1) c[rd_idx] = 1'b1;
      return (m_evt & ~c) | s;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string tag_of_read();
      case (rd_kind)
         2'd0: return "R3";
         2'd1: return "R4";
         default: return "R10";
      endcase
   endfunction

   // One clock: check read data, advance model at the edge, check summary.
   task automatic tick(string rtag = "");
      #1;
      if (rd_en) check(rtag == "" ? tag_of_read() : rtag, rd_data, exp_read());
      @(posedge clk);
      m_sum  = |(m_evt & m_enab);
      m_evt  = exp_next_evt();
      if (filt_wr) m_filt = wdata;
      if (enab_wr) m_enab = wdata;
      m_prev = cond;
      @(negedge clk);
      check("R9", {7'd0, summary}, {7'd0, m_sum});
   endtask

   task automatic quiet();
      filt_wr = 0; enab_wr = 0; rd_en = 0; clr_all = 0; memfail = 0;
   endtask

   task automatic rd(logic [1:0] k, logic [2:0] i, string tag);
      quiet(); rd_en = 1; rd_kind = k; rd_idx = i; tick(tag); rd_en = 0;
   endtask

   task automatic wr_filt(logic [7:0] v);
      quiet(); filt_wr = 1; wdata = v; tick(); filt_wr = 0;
   endtask

   task automatic wr_enab(logic [7:0] v);
      quiet(); enab_wr = 1; wdata = v; tick(); enab_wr = 0;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // Reset state (R10, R3, R9)
      rd(2'd2, 0, "R10");
      rd(2'd3, 0, "R10");
      rd(2'd0, 0, "R3");
      check("R10", rd_data, 8'h00);

      // R1: falling edge of bit 3 with filter 8; rising edge of bit 2 unfiltered
      wr_filt(8'h08);
      rd(2'd2, 0, "R10");
      cond = 8'h08; tick();
      cond = 8'h04; tick();
      rd(2'd1, 3'd3, "R1");
      rd(2'd1, 3'd2, "R1");
      // R4: bit 3 was cleared by the single read
      rd(2'd1, 3'd3, "R4");

      // R2: sticky across idle cycles
      cond = 8'h08; tick(); cond = 8'h00; tick();
      repeat (5) tick();
      rd(2'd0, 0, "R2");
      rd(2'd0, 0, "R3");

      // R9: enable bit 3, summary rises one clock after the event
      wr_enab(8'h08);
      cond = 8'h08; tick(); cond = 8'h00; tick(); tick();
      check("R9", {7'd0, summary}, 8'h01);
      rd(2'd3, 0, "R10");

      // R5: clear-all
      quiet(); clr_all = 1; tick(); clr_all = 0;
      rd(2'd0, 0, "R5");

      // R6: falling edge in the same cycle as a whole read
      cond = 8'h08; tick();
      quiet(); cond = 8'h00; rd_en = 1; rd_kind = 2'd0; tick("R6"); rd_en = 0;
      rd(2'd1, 3'd3, "R6");
      // R6 against clear-all with memfail
      quiet(); clr_all = 1; memfail = 1; tick(); quiet();
      rd(2'd0, 0, "R6");

      // R7: memfail sets bit 5
      quiet(); memfail = 1; tick(); quiet();
      rd(2'd1, 3'd5, "R7");

      // R8: cable loss ignored with motor off, latched when running
      motor_on = 0; startup = 0; cable_ok = 0;
      repeat (4) tick();
      rd(2'd1, 3'd6, "R8");
      motor_on = 1; tick();
      cable_ok = 1; tick();
      rd(2'd1, 3'd6, "R8");
      startup = 1; motor_on = 0; cable_ok = 0; tick();
      startup = 0; cable_ok = 1;
      rd(2'd0, 0, "R8");

      // R11: condition bits 5 and 6 never latch
      wr_filt(8'h60);
      motor_on = 1;
      cond = 8'h60; tick(); cond = 8'h00; tick(); tick();
      rd(2'd0, 0, "R11");
      motor_on = 0;

      // Constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         quiet();
         for (int b = 0; b < 8; b++) if ($urandom_range(3) == 0) cond[b] = ~cond[b];
         if ($urandom_range(15) == 0) begin filt_wr = 1; wdata = 8'($urandom); end
         if ($urandom_range(15) == 0) begin enab_wr = 1; wdata = 8'($urandom); end
         rd_en   = ($urandom_range(2) == 0);
         rd_kind = 2'($urandom);
         rd_idx  = 3'($urandom);
         clr_all = ($urandom_range(63) == 0);
         memfail = ($urandom_range(31) == 0);
         if ($urandom_range(49) == 0) motor_on = ~motor_on;
         startup  = ($urandom_range(39) == 0);
         cable_ok = ($urandom_range(19) != 0);
         tick();
      end
      quiet();
      rd(2'd0, 0, "R3");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule